// File: doc/BRIEF.md
# Event Timer Main Counter and Global Register File

This block owns the free-running 64-bit main counter of a multi-channel event timer. It also owns the timer's global registers, all reached through a plain 32-bit register port with single-cycle reads and writes. A 1 KiB address window is split in two. Offsets below 0x100 hold the block's own registers: two capability words, the global configuration, the interrupt status and the two counter halves. Offsets 0x100 to 0x3FF are 32-byte slots, one per comparator channel. For a slot access the block raises a one-hot select strobe toward the addressed channel and returns that channel's read word.

The counter advances by one on each cycle where the `tick` input is high and the global enable is set. When the enable is clear the counter is frozen, and counting resumes from the held value when the enable is set again. Software may load either 32-bit half at any time. The block broadcasts to the channels the enable level, the legacy-routing flag and two one-cycle pulses. The arm pulse follows an enable rise and the halt pulse follows an enable fall. Each channel applies its own arming condition, for example it ignores the arm pulse while its comparator still holds its all-ones reset value.

Read data comes back one cycle after the request, on `rsp_data` qualified by `rsp_valid`. It carries the state as it stood in the request cycle.

Top module: `evt_main_counter`

## Requirements
- R1: After reset the counter, enable, legacy flag, arm and halt pulses, response valid and slot selects are all zero.
- R2: Offset 0x000 reads the capability word: bits 31:16 vendor code, bit 15 legacy-route capable, bit 13 counter is 64 bits, bits 12:8 channel count minus one, bits 7:0 revision. The default value is 0x8086A201. Offset 0x004 reads the tick period in femtoseconds (default 10,000,000). Writes to both are ignored.
- R3: Offset 0x010 is the configuration register. Bit 0 is the enable and bit 1 is legacy routing, and only these two bits are written. All other bits read zero. Offset 0x014 reads zero and ignores writes.
- R4: While the enable is set, the counter increases by one (modulo 2^64) in every cycle with `tick` high. While the enable is clear it holds its value.
- R5: Offsets 0x0F0 and 0x0F4 read and write the low and high counter halves. A write replaces only its own half and is accepted while the counter runs. A counter write in a cycle that would also advance the counter takes the written value with no increment.
- R6: A read request raises `rsp_valid` in the next cycle. `rsp_data` then holds the addressed value as it stood in the request cycle, before that cycle's counter advance.
- R7: A configuration write that takes the enable from 0 to 1 raises `arm_all` for exactly one cycle, together with the new enable level. A write that takes it from 1 to 0 raises `halt_all` likewise. A write that leaves the enable unchanged raises neither.
- R8: Offset 0x020 reads the channel interrupt status input in its low bits, with the rest zero. Writes to it change no state.
- R9: An access at 0x100 to 0x3FF addresses channel (addr−0x100)>>5. During that access `tmr_sel` has exactly that bit set, combinationally, and a read returns the channel's word from `chan_rdata`. For an index at or above the channel count, no select is raised and the read returns zero.
- R10: Reads of any other offset, including misaligned offsets in the global area, return zero. Writes there change no state.
- R11: `gen_enable` and `legacy_route` mirror configuration bits 0 and 1. `ctr_value` always shows the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Counter advance strobe |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 10 | Byte offset in the register window |
| wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after rd_en |
| rsp_data | output | 32 | Read data |
| irq_status | input | NUM_TIMERS | Per-channel interrupt status |
| chan_rdata | input | 32*NUM_TIMERS | Read word of each channel, channel 0 lowest |
| tmr_sel | output | NUM_TIMERS | One-hot channel slot select during an access |
| gen_enable | output | 1 | Global enable level |
| legacy_route | output | 1 | Legacy routing flag |
| arm_all | output | 1 | One-cycle pulse after an enable rise |
| halt_all | output | 1 | One-cycle pulse after an enable fall |
| ctr_value | output | 64 | Main counter |

## Verification
Two collisions matter most. The first is a counter-half write landing in a cycle where `tick` and the enable would also advance the counter. The second is an enable write landing in a cycle with `tick` high, where the old enable level must decide whether that cycle counts. Both are forced by directed sequences and also arise often under random stimulus with enable writes biased on and `tick` high most of the time. A reference model in the bench applies the write-wins and old-enable rules and compares the counter after every cycle.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int ADDR_W     = 10;
  localparam int WORD_W     = 32;
  localparam int SLOT_SHIFT = 5;
  localparam int MAX_SLOTS  = 24;

  localparam logic [ADDR_W-1:0] OFF_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] SLOT_BASE  = 10'h100;

  typedef enum logic [2:0] {
    RG_NONE, RG_CAP_LO, RG_CAP_HI, RG_CFG, RG_STAT, RG_CNT_LO, RG_CNT_HI, RG_SLOT
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] cap_word(input logic [15:0] vendor,
                                                 input int n_chan,
                                                 input logic [7:0] rev);
    logic [4:0] last;
    last = 5'(n_chan - 1);
    return {vendor, 1'b1, 1'b0, 1'b1, last, rev};
  endfunction
endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
  import evt_ctr_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              slot_hit,
  output logic [IDX_W-1:0]  slot_idx
);
  logic [4:0] idx_full;

  assign idx_full = 5'((addr - SLOT_BASE) >> SLOT_SHIFT);
  assign slot_hit = (addr >= SLOT_BASE) && (int'(idx_full) < NUM_TIMERS);
  assign slot_idx = IDX_W'(idx_full);

  always_comb begin
    if (addr >= SLOT_BASE) begin
      sel = slot_hit ? RG_SLOT : RG_NONE;
    end else begin
      case (addr)
        OFF_CAP_LO: sel = RG_CAP_LO;
        OFF_CAP_HI: sel = RG_CAP_HI;
        OFF_CFG:    sel = RG_CFG;
        OFF_STAT:   sel = RG_STAT;
        OFF_CNT_LO: sel = RG_CNT_LO;
        OFF_CNT_HI: sel = RG_CNT_HI;
        default:    sel = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evt_glb_cfg.sv
module evt_glb_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [1:0] wbits,
  output logic       en,
  output logic       leg,
  output logic       arm,
  output logic       halt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      leg  <= 1'b0;
      arm  <= 1'b0;
      halt <= 1'b0;
    end else begin
      arm  <= wr_stb && wbits[0] && !en;
      halt <= wr_stb && !wbits[0] && en;
      if (wr_stb) begin
        en  <= wbits[0];
        leg <= wbits[1];
      end
    end
  end
endmodule

// File: rtl/evt_main_ctr.sv
module evt_main_ctr #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  // a half write takes priority over the advance in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_lo) begin
      cnt[HALF_W-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt[CNT_W-1:HALF_W] <= wdata;
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_ctr_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter int          TICK_FS    = 10_000_000,
  parameter logic [15:0] VENDOR_ID  = 16'h8086,
  parameter logic [7:0]  REV_ID     = 8'h01,
  localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [WORD_W-1:0]            wdata,
  output logic                         rsp_valid,
  output logic [WORD_W-1:0]            rsp_data,
  input  logic [NUM_TIMERS-1:0]        irq_status,
  input  logic [NUM_TIMERS*WORD_W-1:0] chan_rdata,
  output logic [NUM_TIMERS-1:0]        tmr_sel,
  output logic                         gen_enable,
  output logic                         legacy_route,
  output logic                         arm_all,
  output logic                         halt_all,
  output logic [CNT_W-1:0]             ctr_value
);
  localparam logic [WORD_W-1:0] CAP_LO = cap_word(VENDOR_ID, NUM_TIMERS, REV_ID);
  localparam logic [WORD_W-1:0] CAP_HI = WORD_W'(TICK_FS);

  reg_sel_e         sel;
  logic             slot_hit;
  logic [IDX_W-1:0] slot_idx;
  logic [WORD_W-1:0] rd_word;

  evt_addr_dec #(.NUM_TIMERS(NUM_TIMERS)) u_dec (
    .addr(addr), .sel(sel), .slot_hit(slot_hit), .slot_idx(slot_idx)
  );

  evt_glb_cfg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_en && (sel == RG_CFG)),
    .wbits(wdata[1:0]),
    .en(gen_enable), .leg(legacy_route),
    .arm(arm_all), .halt(halt_all)
  );

  evt_main_ctr #(.HALF_W(WORD_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .run(gen_enable && tick),
    .wr_lo(wr_en && (sel == RG_CNT_LO)),
    .wr_hi(wr_en && (sel == RG_CNT_HI)),
    .wdata(wdata),
    .cnt(ctr_value)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_sel
    assign tmr_sel[i] = (rd_en || wr_en) && slot_hit && (int'(slot_idx) == i);
  end

  always_comb begin
    case (sel)
      RG_CAP_LO: rd_word = CAP_LO;
      RG_CAP_HI: rd_word = CAP_HI;
      RG_CFG:    rd_word = {{(WORD_W-2){1'b0}}, legacy_route, gen_enable};
      RG_STAT:   rd_word = {{(WORD_W-NUM_TIMERS){1'b0}}, irq_status};
      RG_CNT_LO: rd_word = ctr_value[WORD_W-1:0];
      RG_CNT_HI: rd_word = ctr_value[CNT_W-1:WORD_W];
      RG_SLOT:   rd_word = chan_rdata[int'(slot_idx)*WORD_W +: WORD_W];
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_word;
    end
  end
endmodule

// File: rtl/evt_main_counter_chk.sv
module evt_main_counter_chk #(
  parameter int NUM_TIMERS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic                  rsp_valid,
  input logic [NUM_TIMERS-1:0] tmr_sel,
  input logic                  gen_enable,
  input logic                  arm_all,
  input logic                  halt_all,
  input logic [63:0]           ctr_value
);
  // R4
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_enable && !wr_en) |=> $stable(ctr_value));
  // R4
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_enable && tick && !wr_en) |=> (ctr_value == $past(ctr_value) + 64'd1));
  // R7
  arm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_enable) |-> arm_all);
  // R7
  arm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_all |-> gen_enable);
  // R7
  halt_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_enable) |-> halt_all);
  // R7
  halt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_all |-> !gen_enable);
  // R6
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
  // R6
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);
  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_sel));
  // R9
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |-> (tmr_sel == '0));
endmodule

bind evt_main_counter evt_main_counter_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .rsp_valid(rsp_valid), .tmr_sel(tmr_sel), .gen_enable(gen_enable),
  .arm_all(arm_all), .halt_all(halt_all), .ctr_value(ctr_value)
);

// File: tb/evt_main_counter_test.sv
module evt_main_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic [NT-1:0] irq_status = '0;
  logic [NT*32-1:0] chan_rdata;
  logic [NT-1:0] tmr_sel;
  logic gen_enable, legacy_route, arm_all, halt_all;
  logic [63:0] ctr_value;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m_cnt = '0;
  logic m_en = 1'b0, m_leg = 1'b0, m_arm = 1'b0, m_halt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_main_counter uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .irq_status(irq_status), .chan_rdata(chan_rdata), .tmr_sel(tmr_sel),
    .gen_enable(gen_enable), .legacy_route(legacy_route), .arm_all(arm_all),
    .halt_all(halt_all), .ctr_value(ctr_value)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] chan_word(input int i);
    return 32'h5100_0000 + 32'h1111 * i;
  endfunction

  function automatic int slot_of(input logic [9:0] a);
    return int'((a - 10'h100) >> 5);
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    if (a >= 10'h100) return (slot_of(a) < NT) ? chan_word(slot_of(a)) : 32'h0;
    case (a)
      10'h000: return 32'h8086_A201;
      10'h004: return 32'd10_000_000;
      10'h010: return {30'b0, m_leg, m_en};
      10'h020: return {29'b0, irq_status};
      10'h0F0: return m_cnt[31:0];
      10'h0F4: return m_cnt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [NT-1:0] exp_sel(input logic acc, input logic [9:0] a);
    logic [NT-1:0] s;
    s = '0;
    if (acc && a >= 10'h100 && slot_of(a) < NT) s[slot_of(a)] = 1'b1;
    return s;
  endfunction

  // one bus cycle: drive after negedge, check after the next posedge
  task automatic step(input logic w, input logic r, input logic [9:0] a,
                      input logic [31:0] d, input logic t, input string tag);
    logic [31:0] exp_rd;
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
    #1;
    chk("R9 slot select", 64'(tmr_sel), 64'(exp_sel(w || r, a)));
    exp_rd = exp_read(a);
    m_arm  = w && a == 10'h010 && d[0] && !m_en;
    m_halt = w && a == 10'h010 && !d[0] && m_en;
    @(posedge clk);
    if (w && a == 10'h0F0)      m_cnt[31:0]  = d;
    else if (w && a == 10'h0F4) m_cnt[63:32] = d;
    else if (m_en && t)         m_cnt = m_cnt + 64'd1;
    if (w && a == 10'h010) begin m_en = d[0]; m_leg = d[1]; end
    #1;
    chk("R4 counter", ctr_value, m_cnt);
    chk("R11 enable/legacy", {62'b0, legacy_route, gen_enable}, {62'b0, m_leg, m_en});
    chk("R7 arm/halt", {62'b0, arm_all, halt_all}, {62'b0, m_arm, m_halt});
    chk("R6 rsp_valid", 64'(rsp_valid), 64'(r));
    if (r) chk(tag, 64'(rsp_data), 64'(exp_rd));
    @(negedge clk);
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    step(1'b0, 1'b1, a, 32'h0, 1'b0, tag);
  endtask
  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic t);
    step(1'b1, 1'b0, a, d, t, "write");
  endtask

  function automatic logic [9:0] pick_addr();
    case ($urandom_range(0, 11))
      0: return 10'h000;  1: return 10'h004;  2: return 10'h010;
      3: return 10'h014;  4: return 10'h020;  5: return 10'h0F0;
      6: return 10'h0F4;  7: return 10'h011;  8: return 10'h3FC;
      9: return 10'h100 + 10'($urandom_range(0, 5)) * 10'h20 + 10'($urandom_range(0, 31));
      10: return 10'h010;
      default: return 10'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NT; i++) chan_rdata[i*32 +: 32] = chan_word(i);
    repeat (3) @(negedge clk);
    // R1 reset state, counter held in reset even with tick high
    tick = 1'b1;
    @(negedge clk);
    chk("R1 reset counter", ctr_value, 64'h0);
    chk("R1 reset flags", {59'b0, gen_enable, legacy_route, arm_all, halt_all, rsp_valid}, 64'h0);
    chk("R1 reset select", 64'(tmr_sel), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 capability words, write ignored
    rd(10'h000, "R2 cap low");
    rd(10'h004, "R2 cap high");
    wr(10'h000, 32'hFFFF_FFFF, 1'b1);
    wr(10'h004, 32'h0, 1'b1);
    rd(10'h000, "R2 cap low after write");
    rd(10'h004, "R2 cap high after write");

    // R3 only two bits written; upper half reads zero, ignores writes
    wr(10'h010, 32'hFFFF_FFFF, 1'b1);
    rd(10'h010, "R3 config masked");
    wr(10'h014, 32'hFFFF_FFFF, 1'b1);
    rd(10'h014, "R3 config upper");
    // R7 same-value rewrite raises no pulse
    wr(10'h010, 32'h3, 1'b1);
    repeat (5) step(1'b0, 1'b0, 10'h0, 32'h0, 1'b1, "R4 run");

    // R5 counter write during tick while running: written value wins
    wr(10'h0F0, 32'h1234_5678, 1'b1);
    rd(10'h0F0, "R5 low half");
    // R4 enable write in a ticking cycle: old level decides
    wr(10'h010, 32'h0, 1'b1);
    repeat (3) step(1'b0, 1'b0, 10'h0, 32'h0, 1'b1, "R4 hold");
    // R5 carry across halves
    wr(10'h0F0, 32'hFFFF_FFFF, 1'b0);
    wr(10'h0F4, 32'h0000_0000, 1'b1);
    wr(10'h010, 32'h1, 1'b1);
    step(1'b0, 1'b0, 10'h0, 32'h0, 1'b1, "R5 carry");
    rd(10'h0F4, "R5 high half after carry");
    // R4 64-bit wraparound
    wr(10'h0F4, 32'hFFFF_FFFF, 1'b0);
    wr(10'h0F0, 32'hFFFF_FFFF, 1'b0);
    step(1'b0, 1'b0, 10'h0, 32'h0, 1'b1, "R4 wrap");
    // R6 read returns value before that cycle's advance
    step(1'b0, 1'b1, 10'h0F0, 32'h0, 1'b1, "R6 pre-advance read");

    // R8 status read and ignored write
    irq_status = 3'b101;
    wr(10'h020, 32'hFFFF_FFFF, 1'b0);
    rd(10'h020, "R8 status");
    rd(10'h010, "R8 config untouched by status write");
    // R9 slots
    rd(10'h140, "R9 slot 2");
    rd(10'h12C, "R9 slot 1 inner offset");
    rd(10'h160, "R9 slot 3 absent");
    // R10 unmapped and misaligned
    rd(10'h011, "R10 misaligned");
    rd(10'h0F8, "R10 unmapped");
    wr(10'h0F8, 32'hDEAD_BEEF, 1'b0);
    rd(10'h0F0, "R10 counter untouched");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] a;
      logic [31:0] d;
      int kind;
      irq_status = NT'($urandom);
      a = pick_addr();
      d = $urandom;
      if (a == 10'h010 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      kind = $urandom_range(0, 2);
      step(kind == 1, kind == 2, a, d, $urandom_range(0, 9) < 7, "R6 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule